// File: doc/BRIEF.md
# Pipeline Operand Bypass Selector

This block sits in the execute stage of a five-stage in-order pipeline with eight general registers. The five stages are fetch, decode, execute, memory and writeback. The block pulls the two source register numbers out of the instruction word held in the decode/execute latch. It then compares each one with the destination register of the instruction in the execute/memory latch and with the destination register of the instruction in the memory/writeback latch.

For each ALU input it picks one of three values: the value read from the register file in decode, or a newer result that is still travelling down the pipeline. It reports which source it chose on a 2-bit select. The two chosen operands drive an ALU that performs add or nand, and the ALU result is captured in a register on the next rising edge.

When both later stages write the register being read, the younger instruction wins. That instruction is the one in the execute/memory latch. This gives a chain of back-to-back instructions on one register the value each one expects.

Top module: `pipe_bypass_unit`

## Requirements
- R1: Source A is instruction bits [23:21] and source B is bits [17:15] of `idex_instr`. No other instruction bit affects the selection.
- R2: When the execute/memory stage is valid, writes a register, and its destination equals a source, that operand's select is 2'b01 and the operand equals `exm_result`.
- R3: When the memory/writeback stage is valid, writes a register and matches a source, and the execute/memory stage does not match that source, the select is 2'b10 and the operand equals `mwb_result`.
- R4: When both stages match the same source, the execute/memory result is chosen (select 2'b01).
- R5: When no stage matches a source, the select is 2'b00 and the operand equals the decode-stage value (`idex_val_a` or `idex_val_b`).
- R6: A stage that is not valid, or that does not write a register, never supplies an operand, even when its destination number matches.
- R7: Operand A and operand B are resolved independently and may take different sources in the same cycle.
- R8: With `idex_valid` high and `idex_op` = 0 (add), the rising edge loads `alu_res_q` with `opnd_a + opnd_b` modulo 2^32 and sets `alu_vld_q`.
- R9: With `idex_valid` high and `idex_op` = 1 (nand), the rising edge loads `alu_res_q` with `~(opnd_a & opnd_b)`.
- R10: With `idex_valid` low, a rising edge clears `alu_vld_q` and leaves `alu_res_q` unchanged.
- R11: While `rst_n` is low, `alu_vld_q` and `alu_res_q` are 0. They stay 0 through the first two rising edges after `rst_n` rises. The first load can happen on the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| idex_instr | input | 32 | Instruction word in the decode/execute latch |
| idex_val_a | input | 32 | Register-file value read in decode for source A |
| idex_val_b | input | 32 | Register-file value read in decode for source B |
| idex_op | input | 1 | ALU operation: 0 add, 1 nand |
| idex_valid | input | 1 | Decode/execute latch holds a valid instruction |
| exm_valid | input | 1 | Execute/memory latch holds a valid instruction |
| exm_wr | input | 1 | That instruction writes a register |
| exm_dest | input | 3 | Its destination register |
| exm_result | input | 32 | Its ALU result |
| mwb_valid | input | 1 | Memory/writeback latch holds a valid instruction |
| mwb_wr | input | 1 | That instruction writes a register |
| mwb_dest | input | 3 | Its destination register |
| mwb_result | input | 32 | Its result to be written back |
| sel_a | output | 2 | Source of operand A: 00 register file, 01 execute/memory, 10 memory/writeback |
| sel_b | output | 2 | Source of operand B, same encoding |
| opnd_a | output | 32 | Selected operand A |
| opnd_b | output | 32 | Selected operand B |
| alu_res_q | output | 32 | Registered ALU result |
| alu_vld_q | output | 1 | Registered result is valid |

## Verification
The selects and operands depend only on the current latch inputs, so they are due in the same cycle as the stimulus. The bench changes inputs on the falling edge and samples the selects and operands one nanosecond later. The ALU result is due after exactly one rising edge, so the bench samples it at the following falling edge while the inputs are still held. Reset release is checked edge by edge: the first two rising edges after release must leave the result register cleared, and the third must load it.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

  localparam int XLEN      = 32;
  localparam int NREG      = 8;
  localparam int RIDX_W    = $clog2(NREG);
  localparam int SRC_A_LSB = 21;
  localparam int SRC_B_LSB = 15;
  localparam int N_OPND    = 2;

  typedef enum logic [1:0] {
    BYP_RF  = 2'b00,
    BYP_EXM = 2'b01,
    BYP_MWB = 2'b10
  } byp_sel_e;

  typedef enum logic {
    OP_ADD  = 1'b0,
    OP_NAND = 1'b1
  } alu_op_e;

  typedef struct packed {
    logic              vld;
    logic              wr;
    logic [RIDX_W-1:0] dst;
    logic [XLEN-1:0]   data;
  } stage_wb_t;

endpackage

// File: rtl/byp_rst_sync.sv
module byp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/byp_src_fields.sv
module byp_src_fields #(
  parameter int IW     = 32,
  parameter int RIDX_W = 3,
  parameter int A_LSB  = 21,
  parameter int B_LSB  = 15
) (
  input  logic [IW-1:0]     instr,
  output logic [RIDX_W-1:0] src_a,
  output logic [RIDX_W-1:0] src_b
);

  localparam logic [IW-1:0] FIELD_ONES = IW'((1 << RIDX_W) - 1);
  localparam logic [IW-1:0] USED_MASK  = (FIELD_ONES << A_LSB) | (FIELD_ONES << B_LSB);

  logic unused_instr_bits;

  assign src_a = instr[A_LSB +: RIDX_W];
  assign src_b = instr[B_LSB +: RIDX_W];
  assign unused_instr_bits = ^(instr & ~USED_MASK);

endmodule

// File: rtl/byp_operand_mux.sv
module byp_operand_mux
  import bypass_pkg::*;
(
  input  logic [RIDX_W-1:0] src,
  input  logic [XLEN-1:0]   rf_val,
  input  stage_wb_t         exm,
  input  stage_wb_t         mwb,
  output byp_sel_e          sel,
  output logic [XLEN-1:0]   opnd
);

  logic exm_hit;
  logic mwb_hit;

  always_comb begin
    exm_hit = exm.vld && exm.wr && (exm.dst == src);
    mwb_hit = mwb.vld && mwb.wr && (mwb.dst == src);
    if (exm_hit) begin
      sel  = BYP_EXM;
      opnd = exm.data;
    end else if (mwb_hit) begin
      sel  = BYP_MWB;
      opnd = mwb.data;
    end else begin
      sel  = BYP_RF;
      opnd = rf_val;
    end
  end

endmodule

// File: rtl/byp_alu.sv
module byp_alu
  import bypass_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);

  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_NAND: y = ~(a & b);
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/pipe_bypass_unit.sv
module pipe_bypass_unit
  import bypass_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] idex_instr,
  input  logic [31:0] idex_val_a,
  input  logic [31:0] idex_val_b,
  input  logic        idex_op,
  input  logic        idex_valid,
  input  logic        exm_valid,
  input  logic        exm_wr,
  input  logic [2:0]  exm_dest,
  input  logic [31:0] exm_result,
  input  logic        mwb_valid,
  input  logic        mwb_wr,
  input  logic [2:0]  mwb_dest,
  input  logic [31:0] mwb_result,
  output logic [1:0]  sel_a,
  output logic [1:0]  sel_b,
  output logic [31:0] opnd_a,
  output logic [31:0] opnd_b,
  output logic [31:0] alu_res_q,
  output logic        alu_vld_q
);

  logic rst_q_n;

  byp_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  logic [RIDX_W-1:0] src_arr [N_OPND];
  logic [XLEN-1:0]   rf_arr  [N_OPND];
  logic [XLEN-1:0]   opnd_arr[N_OPND];
  byp_sel_e          sel_arr [N_OPND];
  stage_wb_t         exm_bus;
  stage_wb_t         mwb_bus;

  byp_src_fields #(
    .IW     (32),
    .RIDX_W (RIDX_W),
    .A_LSB  (SRC_A_LSB),
    .B_LSB  (SRC_B_LSB)
  ) u_fields (
    .instr (idex_instr),
    .src_a (src_arr[0]),
    .src_b (src_arr[1])
  );

  assign rf_arr[0] = idex_val_a;
  assign rf_arr[1] = idex_val_b;
  assign exm_bus   = '{vld: exm_valid, wr: exm_wr, dst: exm_dest, data: exm_result};
  assign mwb_bus   = '{vld: mwb_valid, wr: mwb_wr, dst: mwb_dest, data: mwb_result};

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    byp_operand_mux u_mux (
      .src    (src_arr[g]),
      .rf_val (rf_arr[g]),
      .exm    (exm_bus),
      .mwb    (mwb_bus),
      .sel    (sel_arr[g]),
      .opnd   (opnd_arr[g])
    );
  end

  assign sel_a  = sel_arr[0];
  assign sel_b  = sel_arr[1];
  assign opnd_a = opnd_arr[0];
  assign opnd_b = opnd_arr[1];

  logic [XLEN-1:0] alu_y;

  byp_alu u_alu (
    .op (alu_op_e'(idex_op)),
    .a  (opnd_arr[0]),
    .b  (opnd_arr[1]),
    .y  (alu_y)
  );

  logic [XLEN-1:0] res_d;
  logic            vld_d;

  always_comb begin
    vld_d = idex_valid;
    res_d = alu_res_q;
    if (idex_valid) res_d = alu_y;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      alu_vld_q <= 1'b0;
      alu_res_q <= '0;
    end else begin
      alu_vld_q <= vld_d;
      alu_res_q <= res_d;
    end
  end

endmodule

// File: rtl/pipe_bypass_unit_chk.sv
module pipe_bypass_unit_chk
  import bypass_pkg::*;
(
  input logic        clk,
  input logic        rst_q_n,
  input logic [31:0] idex_instr,
  input logic [31:0] idex_val_a,
  input logic [31:0] idex_val_b,
  input logic        idex_op,
  input logic        idex_valid,
  input logic        exm_valid,
  input logic        exm_wr,
  input logic [2:0]  exm_dest,
  input logic [31:0] exm_result,
  input logic        mwb_valid,
  input logic        mwb_wr,
  input logic [2:0]  mwb_dest,
  input logic [31:0] mwb_result,
  input logic [1:0]  sel_a,
  input logic [1:0]  sel_b,
  input logic [31:0] opnd_a,
  input logic [31:0] opnd_b,
  input logic [31:0] alu_res_q,
  input logic        alu_vld_q
);

  logic [2:0] ra;
  logic [2:0] rb;
  assign ra = idex_instr[SRC_A_LSB +: RIDX_W];
  assign rb = idex_instr[SRC_B_LSB +: RIDX_W];

  // R2
  exm_fwd_a_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (exm_valid && exm_wr && exm_dest == ra) |-> (sel_a == 2'b01 && opnd_a == exm_result));

  // R3
  mwb_fwd_b_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mwb_valid && mwb_wr && mwb_dest == rb && !(exm_valid && exm_wr && exm_dest == rb))
      |-> (sel_b == 2'b10 && opnd_b == mwb_result));

  // R4
  younger_wins_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (exm_valid && exm_wr && mwb_valid && mwb_wr && exm_dest == rb && mwb_dest == rb)
      |-> (sel_b != 2'b10));

  // R5
  rf_pass_a_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sel_a == 2'b00) |-> (opnd_a == idex_val_a));

  // R5
  rf_pass_b_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sel_b == 2'b00) |-> (opnd_b == idex_val_b));

  // R6
  idle_stage_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(mwb_valid && mwb_wr) |-> (sel_a != 2'b10 && sel_b != 2'b10));

  // R7
  sel_code_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0(sel_a) && $onehot0(sel_b));

  // R8
  add_res_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (idex_valid && !idex_op) |=> (alu_vld_q && alu_res_q == $past(opnd_a) + $past(opnd_b)));

  // R9
  nand_res_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (idex_valid && idex_op) |=> (alu_vld_q && alu_res_q == ~($past(opnd_a) & $past(opnd_b))));

  // R10
  hold_res_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !idex_valid |=> (!alu_vld_q && $stable(alu_res_q)));

endmodule

bind pipe_bypass_unit pipe_bypass_unit_chk u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .idex_instr (idex_instr),
  .idex_val_a (idex_val_a),
  .idex_val_b (idex_val_b),
  .idex_op    (idex_op),
  .idex_valid (idex_valid),
  .exm_valid  (exm_valid),
  .exm_wr     (exm_wr),
  .exm_dest   (exm_dest),
  .exm_result (exm_result),
  .mwb_valid  (mwb_valid),
  .mwb_wr     (mwb_wr),
  .mwb_dest   (mwb_dest),
  .mwb_result (mwb_result),
  .sel_a      (sel_a),
  .sel_b      (sel_b),
  .opnd_a     (opnd_a),
  .opnd_b     (opnd_b),
  .alu_res_q  (alu_res_q),
  .alu_vld_q  (alu_vld_q)
);

// File: tb/pipe_bypass_unit_tb.sv
`timescale 1ns/1ps
module pipe_bypass_unit_tb;

  logic        clk;
  logic        rst_n;
  logic [31:0] idex_instr;
  logic [31:0] idex_val_a;
  logic [31:0] idex_val_b;
  logic        idex_op;
  logic        idex_valid;
  logic        exm_valid;
  logic        exm_wr;
  logic [2:0]  exm_dest;
  logic [31:0] exm_result;
  logic        mwb_valid;
  logic        mwb_wr;
  logic [2:0]  mwb_dest;
  logic [31:0] mwb_result;
  logic [1:0]  sel_a;
  logic [1:0]  sel_b;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic [31:0] alu_res_q;
  logic        alu_vld_q;

  pipe_bypass_unit u_dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [2:0] ra;
    logic [2:0] rb;
    logic       op;
    logic       exv;
    logic       exw;
    logic [2:0] exd;
    logic       mwv;
    logic       mww;
    logic [2:0] mwd;
    logic [1:0] sa;
    logic [1:0] sb;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 3'd2, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 3'd2, 2'b00, 2'b00}, // R5 nothing valid
    '{3'd3, 3'd4, 1'b1, 1'b1, 1'b1, 3'd3, 1'b0, 1'b0, 3'd0, 2'b01, 2'b00}, // R2 add then nand on R3
    '{3'd1, 3'd1, 1'b0, 1'b1, 1'b1, 3'd1, 1'b1, 1'b1, 3'd1, 2'b01, 2'b01}, // R4 chain on R1
    '{3'd5, 3'd6, 1'b0, 1'b1, 1'b1, 3'd2, 1'b1, 1'b1, 3'd5, 2'b10, 2'b00}, // R3
    '{3'd6, 3'd5, 1'b1, 1'b1, 1'b1, 3'd5, 1'b1, 1'b1, 3'd6, 2'b10, 2'b01}, // R7 mixed sources
    '{3'd7, 3'd7, 1'b0, 1'b0, 1'b1, 3'd7, 1'b1, 1'b0, 3'd7, 2'b00, 2'b00}, // R6 invalid / no write
    '{3'd0, 3'd0, 1'b0, 1'b1, 1'b1, 3'd0, 1'b1, 1'b1, 3'd4, 2'b01, 2'b01}, // R2 register zero
    '{3'd2, 3'd4, 1'b1, 1'b1, 1'b0, 3'd2, 1'b1, 1'b1, 3'd2, 2'b10, 2'b00}, // R6 exm no write, R3
    '{3'd4, 3'd3, 1'b1, 1'b1, 1'b1, 3'd3, 1'b0, 1'b1, 3'd4, 2'b00, 2'b01}, // R6 mwb invalid
    '{3'd7, 3'd0, 1'b1, 1'b1, 1'b1, 3'd6, 1'b1, 1'b1, 3'd1, 2'b00, 2'b00}  // R5 no match
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_instr(input logic [2:0] ra, input logic [2:0] rb);
    logic [31:0] w;
    w = 32'h5A3C_96E1;
    w[23:21] = ra;
    w[17:15] = rb;
    return w;
  endfunction

  function automatic logic [31:0] pick(input logic [1:0] s, input logic [31:0] rf,
                                       input logic [31:0] ex, input logic [31:0] mw);
    if (s == 2'b01)      return ex;
    else if (s == 2'b10) return mw;
    else                 return rf;
  endfunction

  function automatic string sel_tag(input logic [1:0] s);
    if (s == 2'b01)      return "R2 sel";
    else if (s == 2'b10) return "R3 sel";
    else                 return "R5 sel";
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] ea;
    logic [31:0] eb;
    logic [31:0] er;
    rst_n      = 1'b0;
    idex_instr = '0;
    idex_val_a = '0;
    idex_val_b = '0;
    idex_op    = 1'b0;
    idex_valid = 1'b0;
    exm_valid  = 1'b0;
    exm_wr     = 1'b0;
    exm_dest   = '0;
    exm_result = '0;
    mwb_valid  = 1'b0;
    mwb_wr     = 1'b0;
    mwb_dest   = '0;
    mwb_result = '0;

    // R11 reset state and synchronous release
    repeat (3) @(negedge clk);
    chk("R11 vld in reset", {31'd0, alu_vld_q}, 32'd0);
    chk("R11 res in reset", alu_res_q, 32'd0);
    idex_instr = mk_instr(3'd1, 3'd2);
    idex_val_a = 32'h0000_1234;
    idex_val_b = 32'h0000_0111;
    idex_valid = 1'b1;
    rst_n      = 1'b1;
    @(negedge clk);
    chk("R11 vld edge1", {31'd0, alu_vld_q}, 32'd0);
    @(negedge clk);
    chk("R11 vld edge2", {31'd0, alu_vld_q}, 32'd0);
    chk("R11 res edge2", alu_res_q, 32'd0);
    @(negedge clk);
    chk("R11 vld edge3", {31'd0, alu_vld_q}, 32'd1);
    chk("R8 first add", alu_res_q, 32'h0000_1345);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idex_instr = mk_instr(VECS[i].ra, VECS[i].rb);
      idex_val_a = 32'h0100_0000 + 32'(i) * 32'h1111;
      idex_val_b = 32'h0200_00F0 ^ (32'(i) << 4);
      idex_op    = VECS[i].op;
      idex_valid = 1'b1;
      exm_valid  = VECS[i].exv;
      exm_wr     = VECS[i].exw;
      exm_dest   = VECS[i].exd;
      exm_result = 32'hE000_0000 | (32'(i) * 7);
      mwb_valid  = VECS[i].mwv;
      mwb_wr     = VECS[i].mww;
      mwb_dest   = VECS[i].mwd;
      mwb_result = 32'h7000_0000 + 32'(i) * 13;
      #1;
      ea = pick(VECS[i].sa, idex_val_a, exm_result, mwb_result);
      eb = pick(VECS[i].sb, idex_val_b, exm_result, mwb_result);
      er = VECS[i].op ? ~(ea & eb) : (ea + eb);
      chk(sel_tag(VECS[i].sa), {30'd0, sel_a}, {30'd0, VECS[i].sa});
      chk(sel_tag(VECS[i].sb), {30'd0, sel_b}, {30'd0, VECS[i].sb});
      chk("R7 opnd_a", opnd_a, ea);
      chk("R7 opnd_b", opnd_b, eb);
      @(negedge clk);
      chk(VECS[i].op ? "R9 nand result" : "R8 add result", alu_res_q, er);
      chk("R8 result valid", {31'd0, alu_vld_q}, 32'd1);
    end

    // R1 matches outside the source fields are ignored
    @(negedge clk);
    idex_instr = 32'h0510_5005;
    idex_instr[23:21] = 3'd1;
    idex_instr[17:15] = 3'd2;
    idex_val_a = 32'hAAAA_0001;
    idex_val_b = 32'h5555_0002;
    idex_op    = 1'b0;
    exm_valid  = 1'b1;
    exm_wr     = 1'b1;
    exm_dest   = 3'd5;
    exm_result = 32'hDEAD_BEEF;
    mwb_valid  = 1'b1;
    mwb_wr     = 1'b1;
    mwb_dest   = 3'd5;
    mwb_result = 32'hFEED_F00D;
    #1;
    chk("R1 sel_a", {30'd0, sel_a}, 32'd0);
    chk("R1 sel_b", {30'd0, sel_b}, 32'd0);
    chk("R1 opnd_a", opnd_a, 32'hAAAA_0001);
    @(negedge clk);
    chk("R8 add after R1", alu_res_q, 32'hFFFF_0003);

    // R10 hold when no valid instruction
    idex_valid = 1'b0;
    idex_op    = 1'b1;
    idex_val_a = 32'h0;
    @(negedge clk);
    chk("R10 vld cleared", {31'd0, alu_vld_q}, 32'd0);
    chk("R10 res held", alu_res_q, 32'hFFFF_0003);
    @(negedge clk);
    chk("R10 res held again", alu_res_q, 32'hFFFF_0003);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule